// File: doc/BRIEF.md
# Drift-Corrected Schedule Tick Generator

This block paces a time-aware gate schedule engine. It divides a stream of scheduler ticks into deltas whose nominal length is 25 ticks (200 ns at the scheduler tick rate). It emits a strobe at the end of every delta. The scheduler ticks and the PTP time counter run from one oscillator, but the PTP counter can be rate-adjusted by a servo outside this block. Over time the two drift apart.

The block watches the PTP time over a programmable correction window, which is measured in PTP ticks. When a window closes, the block compares the PTP time that has elapsed with the number of scheduler ticks it counted. The difference is the drift, and it is added to a signed residual. Every following delta is then lengthened or shortened by up to 5 ticks until the residual is used up. A delta therefore lasts 25 ticks only on average.

Scheduling begins when the PTP time first reaches the programmed base time while the block is enabled. Dropping the enable stops the block and clears all of its state.

Top module: `sched_tick_gen`

## Requirements
- R1: While reset is high, and while the block is not running, `delta_stb` and `period_stb` stay low.
- R2: With `run_en` high, running starts in the first cycle in which `ptp_time >= base_time` (unsigned). No strobe occurs before that cycle. The first `delta_stb` comes on the 25th cycle with `tick_en` high after the start cycle.
- R3: With no drift, each delta spans exactly 25 cycles with `tick_en` high. Cycles with `tick_en` low do not advance the delta.
- R4: A correction window ends in the first running cycle in which `ptp_time` minus the window start is at least `corr_period`. The next window starts `corr_period` later. `period_stb` is asserted on the first `delta_stb` at or after that cycle, and never without `delta_stb`.
- R5: At each window end, the drift is the PTP ticks elapsed minus the scheduler ticks counted in that window. A positive drift shortens the deltas that follow; a negative drift lengthens them. The change starts with the delta that begins at that `period_stb`.
- R6: Each delta is corrected by at most 5 ticks, so every delta is between 20 and 25+5=30 ticks long.
- R7: Drift larger than 5 ticks is held in a signed residual and spread over the following deltas until it is used up. For example, +12 gives delta lengths 20, 20, 23, 25.
- R8: When `run_en` is low in one cycle, both strobes are low from the next cycle on. The tick counter, drift measurement and residual are all cleared, so a restart produces nominal deltas again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enable; low stops the block and clears its state |
| tick_en | input | 1 | Scheduler tick for this cycle |
| ptp_time | input | TIME_W | PTP time, in tick units |
| base_time | input | TIME_W | PTP time at which scheduling starts |
| corr_period | input | TIME_W | Correction window length, in PTP ticks |
| delta_stb | output | 1 | Last tick of a delta |
| period_stb | output | 1 | First delta strobe of a new correction window |

## Verification
The bench first drives a PTP counter that advances exactly with the ticks. This shows that the nominal 25-tick delta holds and that the window boundary falls on every fourth strobe. The same run is repeated with ticks present only every other cycle, which separates tick counting from cycle counting.

A single PTP jump of +12 tests the shortening of deltas, the 5-tick limit and the carried residual. A 7-tick PTP stall tests the lengthening case, and it also places the boundary strictly between two strobes.

A future base time shows that the block holds off until the PTP time reaches it. A stop taken while a residual is still pending, followed by a restart, shows that all state is cleared.

// File: rtl/sched_tick_pkg.sv
package sched_tick_pkg;

    localparam int     RES_W  = 16;
    localparam longint RES_HI = (longint'(1) <<< (RES_W - 1)) - 1;
    localparam longint RES_LO = -(longint'(1) <<< (RES_W - 1));

    typedef logic signed [RES_W-1:0] resid_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic   hit;
        resid_t drift;
    } boundary_t;

    function automatic resid_t sat_resid(input longint v);
        if (v > RES_HI) return resid_t'(RES_HI);
        if (v < RES_LO) return resid_t'(RES_LO);
        return resid_t'(v);
    endfunction

    function automatic resid_t clamp_step(input resid_t v, input int lim);
        if (longint'(v) > longint'(lim))  return resid_t'(lim);
        if (longint'(v) < -longint'(lim)) return resid_t'(-lim);
        return v;
    endfunction

endpackage

// File: rtl/stg_start_ctl.sv
module stg_start_ctl
    import sched_tick_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [TIME_W-1:0] ptp_time,
    input  logic [TIME_W-1:0] base_time,
    output logic              start,
    output logic              active
);

    run_state_e state_q;

    assign active = (state_q == ST_RUN);
    assign start  = run_en && !active && (ptp_time >= base_time);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (!run_en) begin
            state_q <= ST_IDLE;
        end else if (start) begin
            state_q <= ST_RUN;
        end
    end

    AST_START_AT_BASE: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(ptp_time >= base_time))
        else $error("run began before base time"); // R2

endmodule

// File: rtl/stg_drift_meter.sv
module stg_drift_meter
    import sched_tick_pkg::*;
#(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic              tick_en,
    input  logic [TIME_W-1:0] ptp_time,
    input  logic [TIME_W-1:0] corr_period,
    output boundary_t         bnd
);

    logic [TIME_W-1:0]        win_start_q;
    logic [TIME_W-1:0]        ticks_q;
    logic [TIME_W-1:0]        elapsed;
    logic signed [TIME_W-1:0] gap;

    always_comb begin
        elapsed   = ptp_time - win_start_q;
        gap       = $signed(elapsed - ticks_q);
        bnd.hit   = active && (elapsed >= corr_period);
        bnd.drift = sat_resid(longint'(gap));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_start_q <= '0;
            ticks_q     <= '0;
        end else if (start) begin
            win_start_q <= ptp_time;
            ticks_q     <= TIME_W'(tick_en);
        end else if (!active) begin
            win_start_q <= '0;
            ticks_q     <= '0;
        end else if (bnd.hit) begin
            win_start_q <= win_start_q + corr_period;
            ticks_q     <= elapsed - corr_period + TIME_W'(tick_en);
        end else begin
            ticks_q     <= ticks_q + TIME_W'(tick_en);
        end
    end

endmodule

// File: rtl/stg_resid_ctl.sv
module stg_resid_ctl
    import sched_tick_pkg::*;
#(
    parameter int NOM_LEN = 25,
    parameter int MAX_ADJ = 5,
    parameter int CW      = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  boundary_t     bnd,
    input  logic          strobe,
    output logic [CW-1:0] cur_len,
    output logic          period_stb
);

    resid_t resid_q;
    resid_t resid_eff;
    resid_t step;
    logic   pending_q;

    always_comb begin
        resid_eff  = sat_resid(longint'(resid_q) +
                               (bnd.hit ? longint'(bnd.drift) : longint'(0)));
        step       = clamp_step(resid_eff, MAX_ADJ);
        period_stb = strobe && (pending_q || bnd.hit);
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            resid_q   <= '0;
            cur_len   <= CW'(NOM_LEN);
            pending_q <= 1'b0;
        end else if (strobe) begin
            resid_q   <= resid_eff - step;
            cur_len   <= CW'(NOM_LEN - int'(step));
            pending_q <= 1'b0;
        end else begin
            resid_q   <= resid_eff;
            if (bnd.hit) pending_q <= 1'b1;
        end
    end

    AST_LEN_IN_BAND: assert property (@(posedge clk) disable iff (rst)
        active |-> (int'(cur_len) >= NOM_LEN - MAX_ADJ) &&
                   (int'(cur_len) <= NOM_LEN + MAX_ADJ))
        else $error("delta length outside band"); // R6

    AST_RESID_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (active && strobe && !bnd.hit && resid_q > 0) |=> (resid_q < $past(resid_q)))
        else $error("positive residual not consumed"); // R7

endmodule

// File: rtl/stg_delta_ctr.sv
module stg_delta_ctr #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          tick_en,
    input  logic [CW-1:0] cur_len,
    output logic          strobe
);

    logic [CW-1:0] cnt_q;

    assign strobe = active && tick_en && (cnt_q == cur_len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= strobe ? '0 : cnt_q + CW'(1);
        end
    end

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q < cur_len))
        else $error("tick count passed delta length"); // R3

endmodule

// File: rtl/sched_tick_gen.sv
module sched_tick_gen
    import sched_tick_pkg::*;
#(
    parameter int TIME_W  = 32,
    parameter int NOM_LEN = 25,
    parameter int MAX_ADJ = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              tick_en,
    input  logic [TIME_W-1:0] ptp_time,
    input  logic [TIME_W-1:0] base_time,
    input  logic [TIME_W-1:0] corr_period,
    output logic              delta_stb,
    output logic              period_stb
);

    localparam int CW = $clog2(NOM_LEN + MAX_ADJ + 1);

    logic          start;
    logic          active;
    boundary_t     bnd;
    logic [CW-1:0] cur_len;

    stg_start_ctl #(.TIME_W(TIME_W)) u_start (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .ptp_time  (ptp_time),
        .base_time (base_time),
        .start     (start),
        .active    (active)
    );

    stg_drift_meter #(.TIME_W(TIME_W)) u_meter (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .active      (active),
        .tick_en     (tick_en),
        .ptp_time    (ptp_time),
        .corr_period (corr_period),
        .bnd         (bnd)
    );

    stg_resid_ctl #(.NOM_LEN(NOM_LEN), .MAX_ADJ(MAX_ADJ), .CW(CW)) u_resid (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .bnd        (bnd),
        .strobe     (delta_stb),
        .cur_len    (cur_len),
        .period_stb (period_stb)
    );

    stg_delta_ctr #(.CW(CW)) u_delta (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .tick_en (tick_en),
        .cur_len (cur_len),
        .strobe  (delta_stb)
    );

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(run_en) |-> (!delta_stb && !period_stb))
        else $error("strobe after disable"); // R8

endmodule

// File: tb/sched_tick_gen_tb.sv
module sched_tick_gen_tb;

    localparam int TW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic          tick_en = 1'b0;
    logic [TW-1:0] ptp = '0;
    logic [TW-1:0] base = '0;
    logic [TW-1:0] corr = TW'(100);
    logic          dstb;
    logic          pstb;
    int            extra = 0;
    bit            hold = 1'b0;
    int            n_vec = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    always @(posedge clk)
        ptp <= ptp + (hold ? TW'(0) : TW'(tick_en)) + TW'(extra);

    sched_tick_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .tick_en     (tick_en),
        .ptp_time    (ptp),
        .base_time   (base),
        .corr_period (corr),
        .delta_stb   (dstb),
        .period_stb  (pstb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            run_en = 1'b0; tick_en = 1'b1; extra = 0; hold = 1'b0;
            #3;
            if (i > 0) chk(!dstb && !pstb, "R8 quiet after disable", int'(dstb), 0);
        end
    endtask

    // Start at the current PTP time, then compare each delta length and period flag.
    task automatic run_seq(input string req, input int n, input int exp_len[8],
                           input bit exp_p[8], input int ex_at, input int ex_val,
                           input int hold_from, input int hold_n, input bit gap);
        int ticks = 0;
        int idx = 0;
        @(negedge clk);
        base = ptp; run_en = 1'b1; tick_en = 1'b1; extra = 0; hold = 1'b0;
        #3;
        chk(!dstb, {req, " no strobe in start cycle"}, int'(dstb), 0);
        for (int c = 1; c < 2000 && idx < n; c++) begin
            @(negedge clk);
            tick_en = gap ? (c % 2 == 0) : 1'b1;
            extra   = (c == ex_at) ? ex_val : 0;
            hold    = (c >= hold_from) && (c < hold_from + hold_n);
            #3;
            if (tick_en) ticks++;
            if (dstb) begin
                chk(ticks == exp_len[idx], {req, " delta length"}, ticks, exp_len[idx]);
                chk(pstb == exp_p[idx], {req, " R4 period flag"}, int'(pstb), int'(exp_p[idx]));
                ticks = 0;
                idx++;
            end else if (pstb) begin
                chk(1'b0, "R4 period strobe without delta strobe", 1, 0);
            end
        end
        chk(idx == n, {req, " strobe count"}, idx, n);
        extra = 0; hold = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            tick_en = 1'b1; run_en = 1'b0; base = '0;
            #3;
            chk(!dstb && !pstb, "R1 idle outputs low", int'(dstb | pstb), 0);
        end
    endtask

    task automatic t_wait_base();
        int ticks = 0;
        int guard = 0;
        @(negedge clk);
        base = ptp + TW'(40); run_en = 1'b1; tick_en = 1'b1;
        #3;
        while (ptp < base && guard < 200) begin
            chk(!dstb, "R2 no strobe before base time", int'(dstb), 0);
            @(negedge clk);
            #3;
            guard++;
        end
        guard = 0;
        while (guard < 100) begin
            @(negedge clk);
            #3;
            ticks++;
            guard++;
            if (dstb) break;
        end
        chk(ticks == 25, "R2 first strobe after start", ticks, 25);
    endtask

    task automatic t_disable_restart();
        @(negedge clk);
        base = ptp; run_en = 1'b1; tick_en = 1'b1; extra = 0;
        for (int c = 1; c <= 105; c++) begin
            @(negedge clk);
            extra = (c == 10) ? 12 : 0;
        end
        extra = 0;
        go_idle(30);
        run_seq("R8 restart nominal", 4, '{25, 25, 25, 25, 0, 0, 0, 0},
                '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, 0, 0, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_vec, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #3;
        chk(!dstb && !pstb, "R1 outputs low in reset", int'(dstb | pstb), 0);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wait_base();
        go_idle(5);
        // nominal, no drift: R3, R4
        run_seq("R3 nominal", 8, '{25, 25, 25, 25, 25, 25, 25, 25},
                '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, 0, 0, 0, 0, 1'b0);
        go_idle(5);
        // ticks every other cycle: R3 counts ticks only
        run_seq("R3 gapped ticks", 8, '{25, 25, 25, 25, 25, 25, 25, 25},
                '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, 0, 0, 0, 0, 1'b1);
        go_idle(5);
        // PTP jumps +12: R5 shorten, R6 limit, R7 residual carry
        run_seq("R5 R6 R7 positive drift", 8, '{25, 25, 25, 25, 20, 20, 23, 25},
                '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, 10, 12, 0, 0, 1'b0);
        go_idle(5);
        // PTP stalls 7 ticks: R5 lengthen, boundary mid-delta (R4)
        run_seq("R5 R6 negative drift", 8, '{25, 25, 25, 25, 25, 30, 27, 25},
                '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, 0, 0, 10, 7, 1'b0);
        go_idle(5);
        t_disable_restart();
        go_idle(5);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule